// File: doc/BRIEF.md
# Interrupt Source Masking Register Bank

This block gathers interrupt requests from 32 level-sensitive hardware lines and from 32 software-settable bits. Each source has an enable bit and a routing bit that sends it either to the normal path or to the fast path. The block produces three status vectors and one fast-interrupt line. The raw vector shows every asserted source. The normal vector shows the enabled sources that are routed to the normal path. The fast vector shows the sources routed to the fast path, whether or not they are enabled. The fast line is high whenever any fast source is pending.

Software reaches the block through a word-addressed register port with a combinational read path. Enables and software bits are never written whole. Separate registers set them and clear them by writing ones, so one bit can change without a read-modify-write. The normal status vector is a port of its own, so a separate priority unit can arbitrate among the normal requests. A one-bit protection flag is stored and read back but is not enforced.

Top module: `irq_mask_bank`

## Requirements
- R1: The hardware lines are registered on the rising clock edge. The raw status is the OR of the registered lines and the software bits, so a change on a line shows up one cycle later.
- R2: The normal status is raw AND enable AND NOT routing-select, bit by bit.
- R3: The fast status is raw AND routing-select. The enable bits do not gate it.
- R4: The fast-interrupt output is 1 exactly when the fast status is nonzero.
- R5: A write to word offset 4 ORs the data into the enables. A write to offset 4 reads back as the enables. A write to offset 5 clears every enable bit that is written as one.
- R6: A write to offset 6 sets the software bits that are written as one, and a write to offset 7 clears them. Offset 6 reads back the software bits.
- R7: A write to offset 3 replaces the routing-select vector, which reads back at offset 3. A write to offset 0 changes no state.
- R8: A write to offset 8 keeps only data bit 0 as the protection flag. Offset 8 reads the flag zero-extended.
- R9: Reads of offsets 0, 1 and 2 return the normal, fast and raw status.
- R10: Reads of offsets 5 and 7, and of offsets 9 to 15, return zero.
- R11: Reset clears the enables, the routing selects, the software bits, the protection flag and the registered lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hwIrq | input | 32 | Hardware interrupt levels |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register word offset |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Combinational read data for `addr` |
| normStatus | output | 32 | Enabled, normal-routed pending sources |
| fastStatus | output | 32 | Fast-routed pending sources |
| rawStatus | output | 32 | All pending sources |
| fastIrq | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach is a source that is routed to the fast path while its enable bit is clear. Such a source must appear in the fast status and drive the fast line, but must stay out of the normal status. The stimulus enables only part of the asserted lines and then routes a disabled source to the fast path, so a wrong enable gate on either path changes a visible vector. Write-one-to-clear is tested on a vector that has neighbouring bits set, and an ignored write to offset 0 is followed by reads of every stored register. A seeded sequence then mixes line patterns, routing and set/clear writes, and every vector is compared after each round.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;

  // Word offsets; software decodes these, so the values are fixed.
  localparam int unsigned OFF_NORM   = 0;
  localparam int unsigned OFF_FAST   = 1;
  localparam int unsigned OFF_RAW    = 2;
  localparam int unsigned OFF_SEL    = 3;
  localparam int unsigned OFF_ENSET  = 4;
  localparam int unsigned OFF_ENCLR  = 5;
  localparam int unsigned OFF_SWSET  = 6;
  localparam int unsigned OFF_SWCLR  = 7;
  localparam int unsigned OFF_PROT   = 8;

  typedef struct packed {
    logic selWr;
    logic enSet;
    logic enClr;
    logic swSet;
    logic swClr;
    logic protWr;
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    RD_NORM, RD_FAST, RD_RAW, RD_SEL, RD_EN, RD_SOFT, RD_PROT, RD_ZERO
  } readSel_t;

endpackage

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobes_t      strobes,
  output readSel_t          rdSel
);

  localparam logic [ADDR_W-1:0] A_NORM  = ADDR_W'(OFF_NORM);
  localparam logic [ADDR_W-1:0] A_FAST  = ADDR_W'(OFF_FAST);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFF_RAW);
  localparam logic [ADDR_W-1:0] A_SEL   = ADDR_W'(OFF_SEL);
  localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(OFF_ENSET);
  localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(OFF_ENCLR);
  localparam logic [ADDR_W-1:0] A_SWSET = ADDR_W'(OFF_SWSET);
  localparam logic [ADDR_W-1:0] A_SWCLR = ADDR_W'(OFF_SWCLR);
  localparam logic [ADDR_W-1:0] A_PROT  = ADDR_W'(OFF_PROT);

  // Write decode: offset 0 and any unmapped offset raise no strobe.
  always_comb begin
    strobes = '0;
    if (wrEn) begin
      unique case (addr)
        A_SEL:   strobes.selWr  = 1'b1;
        A_ENSET: strobes.enSet  = 1'b1;
        A_ENCLR: strobes.enClr  = 1'b1;
        A_SWSET: strobes.swSet  = 1'b1;
        A_SWCLR: strobes.swClr  = 1'b1;
        A_PROT:  strobes.protWr = 1'b1;
        default: strobes = '0;
      endcase
    end
  end

  // Read decode: write-only and unmapped offsets select zero.
  always_comb begin
    unique case (addr)
      A_NORM:  rdSel = RD_NORM;
      A_FAST:  rdSel = RD_FAST;
      A_RAW:   rdSel = RD_RAW;
      A_SEL:   rdSel = RD_SEL;
      A_ENSET: rdSel = RD_EN;
      A_SWSET: rdSel = RD_SOFT;
      A_PROT:  rdSel = RD_PROT;
      default: rdSel = RD_ZERO;
    endcase
  end

endmodule

// File: rtl/irq_mask_dpath.sv
module irq_mask_dpath
  import irq_mask_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N_SRC-1:0] hwIrq,
  input  logic [N_SRC-1:0] wrData,
  input  ctrlStrobes_t     strobes,
  input  readSel_t         rdSel,
  output logic [N_SRC-1:0] rdData,
  output logic [N_SRC-1:0] normStatus,
  output logic [N_SRC-1:0] fastStatus,
  output logic [N_SRC-1:0] rawStatus,
  output logic             fastIrq
);

  logic [N_SRC-1:0] hwQ;
  logic [N_SRC-1:0] enQ;
  logic [N_SRC-1:0] selQ;
  logic [N_SRC-1:0] softQ;
  logic             protQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hwQ   <= '0;
      enQ   <= '0;
      selQ  <= '0;
      softQ <= '0;
      protQ <= 1'b0;
    end else begin
      hwQ <= hwIrq;
      if (strobes.selWr) selQ <= wrData;
      if (strobes.enSet)      enQ <= enQ | wrData;
      else if (strobes.enClr) enQ <= enQ & ~wrData;
      if (strobes.swSet)      softQ <= softQ | wrData;
      else if (strobes.swClr) softQ <= softQ & ~wrData;
      if (strobes.protWr) protQ <= wrData[0];
    end
  end

  // Per-source status slice.
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign rawStatus[i]  = hwQ[i] | softQ[i];
    assign normStatus[i] = rawStatus[i] & enQ[i] & ~selQ[i];
    assign fastStatus[i] = rawStatus[i] & selQ[i];
  end

  assign fastIrq = |fastStatus;

  always_comb begin
    unique case (rdSel)
      RD_NORM: rdData = normStatus;
      RD_FAST: rdData = fastStatus;
      RD_RAW:  rdData = rawStatus;
      RD_SEL:  rdData = selQ;
      RD_EN:   rdData = enQ;
      RD_SOFT: rdData = softQ;
      RD_PROT: rdData = N_SRC'(protQ);
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_mask_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_SRC-1:0]  hwIrq,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_SRC-1:0]  wrData,
  output logic [N_SRC-1:0]  rdData,
  output logic [N_SRC-1:0]  normStatus,
  output logic [N_SRC-1:0]  fastStatus,
  output logic [N_SRC-1:0]  rawStatus,
  output logic              fastIrq
);

  ctrlStrobes_t strobes;
  readSel_t     rdSel;

  irq_mask_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn    (wrEn),
    .addr    (addr),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  irq_mask_dpath #(.N_SRC(N_SRC)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .hwIrq      (hwIrq),
    .wrData     (wrData),
    .strobes    (strobes),
    .rdSel      (rdSel),
    .rdData     (rdData),
    .normStatus (normStatus),
    .fastStatus (fastStatus),
    .rawStatus  (rawStatus),
    .fastIrq    (fastIrq)
  );

endmodule

// File: rtl/irq_mask_chk.sv
module irq_mask_chk #(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [N_SRC-1:0]  hwIrq,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [N_SRC-1:0]  wrData,
  input logic [N_SRC-1:0]  normStatus,
  input logic [N_SRC-1:0]  fastStatus,
  input logic [N_SRC-1:0]  rawStatus,
  input logic              fastIrq
);

  localparam logic [ADDR_W-1:0] A_SEL   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_SWSET = ADDR_W'(6);

  // Each line that was high on the previous edge shows in raw status.
  assert_raw_holds_line_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((rawStatus & $past(hwIrq)) == $past(hwIrq)));

  assert_norm_within_raw_R2: assert property (@(posedge clk) disable iff (!rstN)
    (normStatus & ~rawStatus) == '0);

  assert_paths_disjoint_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((fastStatus & ~rawStatus) == '0) && ((fastStatus & normStatus) == '0));

  assert_fast_line_R4: assert property (@(posedge clk) disable iff (!rstN)
    fastIrq == (fastStatus != '0));

  assert_enclr_all_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_ENCLR && (&wrData)) |=> (normStatus == '0));

  assert_swset_raises_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_SWSET) |=> ((rawStatus & $past(wrData)) == $past(wrData)));

  assert_sel_routes_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_SEL) |=> (fastStatus == (rawStatus & $past(wrData))));

endmodule

bind irq_mask_bank irq_mask_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hwIrq      (hwIrq),
  .wrEn       (wrEn),
  .addr       (addr),
  .wrData     (wrData),
  .normStatus (normStatus),
  .fastStatus (fastStatus),
  .rawStatus  (rawStatus),
  .fastIrq    (fastIrq)
);

// File: tb/tb_irq_mask_bank.sv
`timescale 1ns/1ps
module tb_irq_mask_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] hwIrq = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, normStatus, fastStatus, rawStatus;
  logic        fastIrq;

  always #2.5 clk = ~clk;

  irq_mask_bank dut (
    .clk(clk), .rstN(rstN), .hwIrq(hwIrq), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .normStatus(normStatus),
    .fastStatus(fastStatus), .rawStatus(rawStatus), .fastIrq(fastIrq)
  );

  // Scoreboard item: kind 0 = rdData, 1 norm, 2 fast, 3 raw, 4 fastIrq.
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference model state.
  logic [31:0] hwM = '0, enM = '0, selM = '0, softM = '0;
  logic        protM = 1'b0;

  function automatic logic [31:0] mRaw();  return hwM | softM; endfunction
  function automatic logic [31:0] mNorm(); return mRaw() & enM & ~selM; endfunction
  function automatic logic [31:0] mFast(); return mRaw() & selM; endfunction

  function automatic logic [31:0] mRead(int a);
    case (a)
      0: return mNorm();
      1: return mFast();
      2: return mRaw();
      3: return selM;
      4: return enM;
      6: return softM;
      8: return {31'b0, protM};
      default: return '0;
    endcase
  endfunction

  // Monitor: samples at the falling edge, away from the active edge.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = rdData;
        1: act = normStatus;
        2: act = fastStatus;
        3: act = rawStatus;
        default: act = {31'b0, fastIrq};
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic doWrite(int a, logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; addr = 4'(a); wrData = d;
    case (a)
      3: selM = d;
      4: enM = enM | d;
      5: enM = enM & ~d;
      6: softM = softM | d;
      7: softM = softM & ~d;
      8: protM = d[0];
      default: ;
    endcase
  endtask

  task automatic doRead(int a, string tag);
    @(posedge clk); #1;
    wrEn = 1'b0; addr = 4'(a);
    push(0, mRead(a), tag);
  endtask

  // Drive new line levels; raw must still show the old sample this cycle.
  task automatic setHw(logic [31:0] v);
    @(posedge clk); #1;
    wrEn = 1'b0; hwIrq = v;
    push(3, mRaw(), "R1 delay");
    hwM = v;
  endtask

  task automatic checkPorts(string tag);
    @(posedge clk); #1;
    wrEn = 1'b0;
    push(1, mNorm(), tag);
    push(2, mFast(), tag);
    push(3, mRaw(), tag);
    push(4, {31'b0, mFast() != 0}, tag);
  endtask

  initial begin : watchdog
    #(100000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    logic [31:0] seed;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R11: reset state
    checkPorts("R11 reset ports");
    for (int a = 0; a < 9; a++) doRead(a, "R11 reset reg");

    // R1: sampled lines
    setHw(32'h0000_00F1);
    checkPorts("R1 raw");

    // R2 / R5: enable set and clear
    doWrite(4, 32'h0000_0031);
    checkPorts("R2 norm");
    doWrite(4, 32'h0000_0100);
    doRead(4, "R5 enable or");
    doWrite(5, 32'h0000_0011);
    doRead(4, "R5 enable clear");
    checkPorts("R2 after clear");

    // R3 / R4 / R7: routing, incl. disabled source 0x80 on fast path
    doWrite(3, 32'h0000_00A0);
    doRead(3, "R7 select");
    checkPorts("R3 R4 fast ungated");

    // R6: software bits
    doWrite(6, 32'h8000_0000);
    doRead(6, "R6 soft set");
    checkPorts("R6 raw");
    doWrite(6, 32'h0000_0001);
    doRead(6, "R6 soft set or");
    doWrite(7, 32'h8000_0000);
    doRead(6, "R6 soft clear");

    // R7: offset 0 write ignored
    doWrite(0, 32'hFFFF_FFFF);
    for (int a = 0; a < 9; a++) doRead(a, "R7 status write ignored");

    // R8: protection
    doWrite(8, 32'hFFFF_FFFE);
    doRead(8, "R8 prot bit0 only");
    doWrite(8, 32'h0000_0003);
    doRead(8, "R8 prot set");

    // R10: zero reads
    doRead(5, "R10 enclr reads zero");
    doRead(7, "R10 swclr reads zero");
    for (int a = 9; a < 16; a++) doRead(a, "R10 unmapped");

    // R9: status reads
    for (int a = 0; a < 3; a++) doRead(a, "R9 status read");

    // R4: fast line drops
    setHw(32'h0);
    checkPorts("R4 fast low");
    doWrite(5, 32'hFFFF_FFFF);
    checkPorts("R5 clear all");

    // Mixed patterns
    seed = 32'h1234_5678;
    for (int i = 0; i < 20; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      setHw(seed);
      seed = seed * 32'd1664525 + 32'd1013904223;
      doWrite(3, seed);
      seed = seed * 32'd1664525 + 32'd1013904223;
      doWrite(4, seed);
      seed = seed * 32'd1664525 + 32'd1013904223;
      doWrite(5, seed & 32'h0F0F_0F0F);
      doWrite(6, {seed[15:0], seed[31:16]} & 32'h0000_FF00);
      doWrite(7, 32'h0000_0F00);
      checkPorts("R2 R3 R4 mixed");
      for (int a = 0; a < 3; a++) doRead(a, "R9 mixed");
    end

    @(posedge clk); #1;
    wrEn = 1'b0;
    repeat (2) @(posedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule